// File: doc/BRIEF.md
# Programmable System Clock Controller

This block selects which of three oscillators feeds the main clock of a small microcontroller, divides that main clock down to the system clock, and optionally sends a divided copy of the main clock to one of two output pins. Each oscillator has its own enable and ready handshake. A start-up debounce counter, driven by a reference tick, decides when a newly enabled oscillator counts as ready. A power-down input stops every source at once.

Everything runs from one fast reference clock. Clock division is done with clock enables and toggle registers, not with gated clocks. Software reaches the controller through a byte-wide register bus with an address, a write strobe, write data and combinational read data. The main clock counts as running on every reference cycle in which the active oscillator is ready and power-down is low.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset the registers read as follows. Address 0 reads 0x00. Address 1 reads 0x00. Address 2 reads 0x80, which means the high-precision oscillator is enabled but not yet ready. Addresses 3, 4 and 5 read 0x00. Address 6 reads 0x80.
- R2: Address 1 holds the system divide value N. While the main clock runs, `sys_ce` pulses once every N main-clock cycles. N = 0 and N = 1 both give a pulse on every cycle.
- R3: Source code 2'b10 is reserved. A write of that code never changes the active source. Address 0 bits 1:0 read back the active source code.
- R4: Source codes are 00 for the high-precision oscillator, 01 for the external oscillator and 11 for the low-speed oscillator. A newly written code becomes active only once the target oscillator reports ready. Until then the previous source stays in use.
- R5: A new divide value takes effect only when the running divide period ends. The period in progress completes with the old value.
- R6: Each oscillator has a control register: address 2 for the high-precision oscillator, 3 for the external oscillator and 4 for the low-speed oscillator. Bit 7 is the enable and bit 0 is the read-only ready flag. The ready flag sets once the number of reference ticks in address 6 has passed since enable. In address 3, bit 6 (source type), bits 5:4 (filter) and bit 3 (gain) are stored and read back. The other bits read 0.
- R7: While `pwr_down` is high, all of the following hold: `osc_en` is 0, every ready flag is cleared, `sys_ce` stays low, and the clock output pins hold their level.
- R8: Address 5 bit 7 selects the output pin: 0 selects `clk_out_a` and 1 selects `clk_out_b`. The pin that is not selected stays low.
- R9: Address 5 bits 6:0 hold M. When M is nonzero, the selected pin toggles every M main-clock cycles. When M is 0, both output pins are low.
- R10: When `pwr_down` is released, each enabled oscillator restarts its debounce count from zero. Its ready flag stays low until that count completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address, 0 to 6 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ref_tick | input | 1 | Reference tick that advances the debounce counters |
| pwr_down | input | 1 | Power-down request; stops all sources |
| osc_en | output | 3 | Oscillator enables: bit 0 high-precision, bit 1 external, bit 2 low-speed |
| sys_ce | output | 1 | System clock enable pulse |
| clk_out_a | output | 1 | Divided main clock, first pin |
| clk_out_b | output | 1 | Divided main clock, second pin |

## Verification
The clock-output hold check during power-down assumes that no register writes happen while `pwr_down` is high. A write to the output control register could legally change the pins at that time. The source-switch check assumes that the ready flags come only from the debounce logic, and the bench never forces them. The stimulus keeps `ref_tick` high on every cycle and leaves the bus idle for the whole power-down interval.

// File: rtl/sysclk_pkg.sv
// Shared types and constants for the system clock controller.
// Assumes three oscillators in a fixed index order: 0 high-precision, 1 external, 2 low-speed.
package sysclk_pkg;
    localparam int NUM_OSC  = 3;
    localparam int REG_W    = 8;
    localparam int OUTDIV_W = 7;

    typedef enum logic [1:0] {
        SRC_HP  = 2'b00,
        SRC_EXT = 2'b01,
        SRC_RSV = 2'b10,
        SRC_LP  = 2'b11
    } src_e;

    localparam logic [2:0] A_SEL  = 3'd0;
    localparam logic [2:0] A_DIV  = 3'd1;
    localparam logic [2:0] A_HP   = 3'd2;
    localparam logic [2:0] A_EXT  = 3'd3;
    localparam logic [2:0] A_LP   = 3'd4;
    localparam logic [2:0] A_OUT  = 3'd5;
    localparam logic [2:0] A_DBNC = 3'd6;

    // Maps a source code to an oscillator index. The reserved code maps to 0 and is never used.
    function automatic int unsigned src_index(src_e s);
        case (s)
            SRC_EXT: return 1;
            SRC_LP:  return 2;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/osc_qualify.sv
// Debounce qualifier for one oscillator.
// Counts reference ticks after the oscillator is enabled and raises ready once the
// count reaches the programmed limit. Disabling the oscillator or power-down clears
// the count and the ready flag, so every restart begins again from zero.
module osc_qualify #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pd,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          rdy
);
    logic [CW-1:0] cnt;

    // Tick counter and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || pd) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else if (!rdy) begin
            if (cnt >= limit)
                rdy <= 1'b1;
            else if (tick)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ce_divider.sv
// Clock-enable divider for the system clock.
// Produces one enable pulse every max(div,1) cycles in which run is high. A new divide
// value is loaded only when the count reaches zero, so the period in progress completes.
module ce_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         ce
);
    logic [W-1:0] cnt;
    logic [W-1:0] reload;

    // Reload value: divide values 0 and 1 both mean a pulse on every cycle.
    always_comb reload = (div <= 1) ? '0 : div - 1'b1;

    // Down counter that reloads at wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run)
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end

    assign ce = run && (cnt == '0);
endmodule

// File: rtl/clkout_gen.sv
// Divided main-clock output routed to one of two pins.
// Toggles every div cycles in which run is high. When div is zero the toggle is
// cleared. When run is low the toggle holds its level.
module clkout_gen #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    input  logic         pin_sel,
    output logic         out_a,
    output logic         out_b
);
    logic [W-1:0] cnt;
    logic         tog;

    // Toggle generator.
    always_ff @(posedge clk) begin
        if (!rst_n || div == '0) begin
            cnt <= '0;
            tog <= 1'b0;
        end else if (run) begin
            if (cnt >= div - 1'b1) begin
                cnt <= '0;
                tog <= ~tog;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign out_a = tog & ~pin_sel;
    assign out_b = tog & pin_sel;
endmodule

// File: rtl/sysclk_ctrl.sv
// System clock controller top.
// Holds the register file, qualifies the three oscillators, switches the main source
// only when its target is ready, and drives the system clock enable and the divided
// output pins. Assumes that clk is the fast reference and that ref_tick is synchronous to it.
module sysclk_ctrl
    import sysclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic                ref_tick,
    input  logic                pwr_down,
    output logic [NUM_OSC-1:0]  osc_en,
    output logic                sys_ce,
    output logic                clk_out_a,
    output logic                clk_out_b
);
    src_e                 act_sel, pend_sel;
    logic [REG_W-1:0]     sys_div, dbnc;
    logic [NUM_OSC-1:0]   en_bits, rdy_vec;
    logic                 x_type, x_gain;
    logic [1:0]           x_filt;
    logic                 out_pin;
    logic [OUTDIV_W-1:0]  out_div;
    logic                 mclk_on;

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_div <= '0;
            dbnc    <= 8'h80;
            en_bits <= 3'b001;
            x_type  <= 1'b0;
            x_filt  <= 2'b00;
            x_gain  <= 1'b0;
            out_pin <= 1'b0;
            out_div <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DIV:  sys_div <= bus_wdata;
                A_HP:   en_bits[0] <= bus_wdata[7];
                A_EXT: begin
                    en_bits[1] <= bus_wdata[7];
                    x_type     <= bus_wdata[6];
                    x_filt     <= bus_wdata[5:4];
                    x_gain     <= bus_wdata[3];
                end
                A_LP:   en_bits[2] <= bus_wdata[7];
                A_OUT: begin
                    out_pin <= bus_wdata[7];
                    out_div <= bus_wdata[6:0];
                end
                A_DBNC: dbnc <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Source selection: hold a request pending until its target is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_sel <= SRC_HP;
            act_sel  <= SRC_HP;
        end else if (bus_wr && bus_addr == A_SEL && src_e'(bus_wdata[1:0]) != SRC_RSV) begin
            pend_sel <= src_e'(bus_wdata[1:0]);
        end else if (pend_sel != act_sel && rdy_vec[src_index(pend_sel)]) begin
            act_sel <= pend_sel;
        end
    end

    assign osc_en  = en_bits & {NUM_OSC{~pwr_down}};
    assign mclk_on = ~pwr_down & rdy_vec[src_index(act_sel)];

    // One debounce qualifier per oscillator.
    for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
        osc_qualify #(.CW(REG_W)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_bits[i]),
            .pd    (pwr_down),
            .tick  (ref_tick),
            .limit (dbnc),
            .rdy   (rdy_vec[i])
        );
    end

    ce_divider #(.W(REG_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mclk_on),
        .div   (sys_div),
        .ce    (sys_ce)
    );

    clkout_gen #(.W(OUTDIV_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mclk_on),
        .div     (out_div),
        .pin_sel (out_pin),
        .out_a   (clk_out_a),
        .out_b   (clk_out_b)
    );

    // Read mux.
    always_comb begin
        case (bus_addr)
            A_SEL:  bus_rdata = {6'b0, act_sel};
            A_DIV:  bus_rdata = sys_div;
            A_HP:   bus_rdata = {en_bits[0], 6'b0, rdy_vec[0]};
            A_EXT:  bus_rdata = {en_bits[1], x_type, x_filt, x_gain, 2'b0, rdy_vec[1]};
            A_LP:   bus_rdata = {en_bits[2], 6'b0, rdy_vec[2]};
            A_OUT:  bus_rdata = {out_pin, out_div};
            A_DBNC: bus_rdata = dbnc;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysclk_ctrl_chk.sv
// Property checker for the system clock controller, bound into every instance.
// Assumes no register writes occur while power-down is high.
module sysclk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_down,
    input logic [1:0] act_sel,
    input logic [2:0] rdy_vec,
    input logic       clk_out_a,
    input logic       clk_out_b
);
    AST_RSV_NEVER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        act_sel != 2'b10); // R3

    AST_SWITCH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel != $past(act_sel)) |->
            ((act_sel == 2'b00 && $past(rdy_vec[0])) ||
             (act_sel == 2'b01 && $past(rdy_vec[1])) ||
             (act_sel == 2'b11 && $past(rdy_vec[2])))); // R4

    AST_PD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (rdy_vec == 3'b000)); // R7

    AST_PD_HOLDS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && $past(pwr_down)) |-> ($stable(clk_out_a) && $stable(clk_out_b))); // R7

    AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_out_a && clk_out_b)); // R8
endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .act_sel   (act_sel),
    .rdy_vec   (rdy_vec),
    .clk_out_a (clk_out_a),
    .clk_out_b (clk_out_b)
);

// File: tb/sysclk_ctrl_test.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares.
module sysclk_ctrl_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ref_tick = 1'b1;
    logic       pwr_down = 1'b0;
    logic [2:0] osc_en;
    logic       sys_ce, clk_out_a, clk_out_b;

    sysclk_ctrl uut (.*);

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        bit    use_meas;
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    meas;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    event  mon_ev;

    // Monitor: pop each expected item and compare it against the design output.
    initial forever begin
        @(mon_ev);
        while (q.size() > 0) begin
            item_t it;
            int act;
            it = q.pop_front();
            act = it.use_meas ? meas : int'(bus_rdata);
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(bit m, int e, string t);
        item_t it;
        it.use_meas = m; it.exp = e; it.tag = t;
        q.push_back(it);
        #1;
        -> mon_ev;
        #1;
    endtask

    task automatic rd_expect(logic [2:0] a, int e, string t);
        @(negedge clk);
        bus_addr = a;
        #1;
        push(1'b0, e, t);
    endtask

    task automatic meas_expect(int e, string t);
        push(1'b1, e, t);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Cycles between two consecutive sys_ce pulses, sampled at negedges.
    task automatic ce_gap(output int g);
        g = 0;
        do @(negedge clk); while (!sys_ce);
        do begin @(negedge clk); g++; end while (!sys_ce);
    endtask

    task automatic count_high(int n, output int ha, output int hb, output int hc);
        ha = 0; hb = 0; hc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ha += clk_out_a; hb += clk_out_b; hc += sys_ce;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    // Stimulus.
    initial begin
        int g, ha, hb, hc;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        rd_expect(3'd0, 8'h00, "R1 sel");
        rd_expect(3'd1, 8'h00, "R1 div");
        rd_expect(3'd2, 8'h80, "R1 hp ctrl");
        rd_expect(3'd3, 8'h00, "R1 ext ctrl");
        rd_expect(3'd4, 8'h00, "R1 lp ctrl");
        rd_expect(3'd5, 8'h00, "R1 out ctrl");
        rd_expect(3'd6, 8'h80, "R1 debounce");
        // R6 debounce of the high-precision oscillator (128 ticks)
        idle(90);
        rd_expect(3'd2, 8'h80, "R6 hp not yet ready");
        idle(40);
        rd_expect(3'd2, 8'h81, "R6 hp ready");
        // R2 divide values
        ce_gap(g); meas = g; meas_expect(1, "R2 div0");
        wr(3'd1, 8'd1);
        ce_gap(g); meas = g; meas_expect(1, "R2 div1");
        wr(3'd1, 8'd5);
        ce_gap(g); meas = g; meas_expect(5, "R2 div5");
        // R4 switch to a disabled source is held off
        wr(3'd6, 8'd4);
        wr(3'd0, 8'h01);
        idle(3);
        rd_expect(3'd0, 8'h00, "R4 held while ext off");
        wr(3'd3, 8'hF8);
        rd_expect(3'd3, 8'hF8, "R6 ext fields, not ready");
        idle(10);
        rd_expect(3'd3, 8'hF9, "R6 ext ready");
        rd_expect(3'd0, 8'h01, "R4 switched to ext");
        // R3 reserved code
        wr(3'd0, 8'h02);
        idle(3);
        rd_expect(3'd0, 8'h01, "R3 reserved ignored");
        // R4 low-speed source
        wr(3'd0, 8'h03);
        idle(3);
        rd_expect(3'd0, 8'h01, "R4 held while lp off");
        wr(3'd4, 8'h80);
        idle(10);
        rd_expect(3'd4, 8'h81, "R6 lp ready");
        rd_expect(3'd0, 8'h03, "R4 switched to lp");
        // R5 new divide at wrap
        wr(3'd1, 8'd8);
        ce_gap(g);
        wr(3'd1, 8'd2);
        g = 0;
        while (!sys_ce) begin @(negedge clk); g++; end
        meas = g; meas_expect(6, "R5 old period completes");
        ce_gap(g); meas = g; meas_expect(2, "R5 new period");
        // R9 / R8 clock output
        wr(3'd5, 8'h03);
        while (clk_out_a) @(negedge clk);
        while (!clk_out_a) @(negedge clk);
        g = 0;
        while (clk_out_a) begin g++; @(negedge clk); end
        meas = g; meas_expect(3, "R9 high time M=3");
        wr(3'd5, 8'h83);
        idle(2);
        count_high(12, ha, hb, hc);
        meas = ha; meas_expect(0, "R8 pin a low when b selected");
        meas = hb; meas_expect(6, "R8 pin b toggles");
        wr(3'd5, 8'h00);
        idle(2);
        count_high(12, ha, hb, hc);
        meas = ha + hb; meas_expect(0, "R9 M=0 both low");
        // R7 power-down
        wr(3'd1, 8'd1);
        @(negedge clk) pwr_down = 1'b1;
        #1;
        meas = int'(osc_en); meas_expect(0, "R7 osc_en off");
        count_high(20, ha, hb, hc);
        meas = hc; meas_expect(0, "R7 no sys_ce");
        rd_expect(3'd3, 8'hF8, "R7 ext ready cleared");
        rd_expect(3'd2, 8'h80, "R7 hp ready cleared");
        // R10 restart after release
        @(negedge clk) pwr_down = 1'b0;
        #1;
        meas = int'(osc_en); meas_expect(7, "R10 enables return");
        idle(1);
        rd_expect(3'd3, 8'hF8, "R10 ready waits for debounce");
        idle(8);
        rd_expect(3'd3, 8'hF9, "R10 ready after debounce");
        done = 1;
        idle(2);
        summary();
    end
endmodule